// File: doc/BRIEF.md
# Reference Oscillator Frequency Classifier

This block finds out which of six standard crystal frequencies drives the fast system clock it runs on. After a start pulse it watches a slow 32 kHz reference clock. It lets a settling interval of reference edges go by, then counts fast-clock cycles over a fixed number of further reference edges. The count is doubled when the incoming clock is known to be pre-divided by two. The result is then placed in one of six classes by a ladder of thresholds that are not evenly spaced.

From the class it produces three outputs: a 3-bit input-select code, an input-divider ratio and a table index. A clock controller uses these to choose its PLL parameter set. The block does not drive a PLL and does not make any clock. It measures once per start pulse and reports with a one-cycle done pulse.

The reference clock is asynchronous to the fast clock. It is brought into the fast domain through a two-flop synchronizer and a rising-edge detector. Each level of the reference clock must last at least two fast cycles.

Top module: `osc_freq_classifier`

## Requirements
- R1: After a synchronous active-low reset the outputs are: busy low, done low, select code 0, divider ratio 1 and table index 0.
- R2: An accepted start opens a settling interval. The first 20 rising reference edges after the start add nothing to the count.
- R3: The count is the number of fast-clock cycles between the 20th and the 40th rising reference edge after start. A count of exactly 7600 with no pre-division classifies as 12 MHz, and 7601 classifies as 13 MHz.
- R4: When the pre-divide input is high at the accepted start, the count is doubled before it is classified. For example, 9500 doubled is 19000, which gives code 3, and 9501 doubled gives code 4.
- R5: Classification uses strict greater-than tests, in order of priority: above 19000 is 38.4 MHz, above 15200 is 26 MHz, above 13000 is 24 MHz, above 9000 is 19.2 MHz, above 7600 is 13 MHz, and any other count is 12 MHz.
- R6: The select code is 4 for 38.4 MHz, 3 for 26 MHz, 2 for 19.2 MHz, 1 for 13 MHz, and 0 for both 24 MHz and 12 MHz.
- R7: When the select code is above 2, the divider ratio output is 2 and the table index is the code shifted right by one. Otherwise the ratio is 1 and the index equals the code.
- R8: The cycle counter is 16 bits wide and holds at 65535 instead of wrapping. A window of 65600 cycles therefore still classifies as 38.4 MHz, code 4.
- R9: Busy rises in the cycle after an accepted start. It falls in the cycle in which done is high, and done lasts exactly one cycle. A start that arrives while busy is ignored and does not restart the measurement.
- R10: The select code, divider ratio and table index are updated together with the done pulse. They hold their values until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock being measured |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a measurement |
| ref_clk_i | input | 1 | Asynchronous 32 kHz reference clock |
| pre_div2_i | input | 1 | High when the measured clock is the crystal divided by two |
| busy_o | output | 1 | High while a measurement is in progress |
| done_o | output | 1 | One-cycle pulse when new results are valid |
| sel_code_o | output | 3 | Input-select code of the detected crystal |
| div_ratio_o | output | 2 | Input divider ratio, 1 or 2 |
| tbl_idx_o | output | 2 | Parameter table index |

## Verification
A wrong edge count in the settle or window phase changes the measured cycle total. This shows up at the select code with the first done pulse, when counts sit right at the 7600 boundary or at the doubled 19000 boundary. A counter that wraps instead of saturating reports 12 MHz instead of 38.4 MHz after a window longer than 65535 cycles. A phase machine that restarts on a second start while busy lengthens busy and shifts the count, so the next done pulse is late or carries another class.

// File: rtl/osc_cls_pkg.sv
// Package: shared constants and types of the oscillator classifier.
// Assumes thresholds are listed in descending order (highest priority first).
package osc_cls_pkg;

    localparam int NUM_CLASSES = 5;

    // Strict-greater thresholds, highest first; anything below the last maps to code 0
    localparam int unsigned LADDER_TH [NUM_CLASSES] = '{19000, 15200, 13000, 9000, 7600};
    localparam logic [2:0]  LADDER_CD [NUM_CLASSES] = '{3'd4, 3'd3, 3'd0, 3'd2, 3'd1};

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETTLE  = 2'd1,
        PH_MEASURE = 2'd2,
        PH_REPORT  = 2'd3
    } phase_t;

endpackage

// File: rtl/osc_ref_sync.sv
// Module: brings the asynchronous reference clock into the fast domain and
// emits a one-cycle tick per rising edge.
// Assumes each reference level lasts at least two fast-clock cycles.
module osc_ref_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_async_i,
    output logic ref_tick_o
);
    logic meta_q, sync_q, prev_q;

    // Two-flop synchronizer plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= ref_async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign ref_tick_o = sync_q & ~prev_q;

    // R3: an edge tick can never occur on two consecutive cycles
    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick_o |=> !ref_tick_o);

endmodule

// File: rtl/osc_window_ctrl.sv
// Module: phase machine that counts reference ticks through the settle and
// measure phases and signals when the result may be reported.
// Assumes ref_tick_i is a one-cycle pulse per reference rising edge.
module osc_window_ctrl
    import osc_cls_pkg::*;
#(
    parameter int SETTLE_TICKS = 20,
    parameter int WINDOW_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ref_tick_i,
    output logic accept_o,
    output logic measure_o,
    output logic report_o,
    output logic busy_o
);
    localparam int MAX_TICKS = (SETTLE_TICKS > WINDOW_TICKS) ? SETTLE_TICKS : WINDOW_TICKS;
    localparam int TW        = $clog2(MAX_TICKS + 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_TICKS - 1);
    localparam logic [TW-1:0] WINDOW_LAST = TW'(WINDOW_TICKS - 1);

    phase_t        phase_q;
    logic [TW-1:0] tick_cnt_q;

    assign accept_o  = start_i && (phase_q == PH_IDLE);
    assign measure_o = (phase_q == PH_MEASURE);
    assign report_o  = (phase_q == PH_REPORT);
    assign busy_o    = (phase_q != PH_IDLE);

    // Advance phases on reference ticks; starts are taken only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            tick_cnt_q <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    tick_cnt_q <= '0;
                    if (start_i) phase_q <= PH_SETTLE;
                end
                PH_SETTLE: if (ref_tick_i) begin
                    if (tick_cnt_q == SETTLE_LAST) begin
                        tick_cnt_q <= '0;
                        phase_q    <= PH_MEASURE;
                    end else begin
                        tick_cnt_q <= tick_cnt_q + 1'b1;
                    end
                end
                PH_MEASURE: if (ref_tick_i) begin
                    if (tick_cnt_q == WINDOW_LAST) begin
                        tick_cnt_q <= '0;
                        phase_q    <= PH_REPORT;
                    end else begin
                        tick_cnt_q <= tick_cnt_q + 1'b1;
                    end
                end
                PH_REPORT: phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // R9: a start during the measure phase does not leave that phase
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (measure_o && start_i && !ref_tick_i) |=> measure_o);

    // R9: the report phase lasts exactly one cycle and is followed by idle
    a_r9_report_once: assert property (@(posedge clk) disable iff (!rst_n)
        report_o |=> !busy_o);

    // R2: the measure phase is only entered from the settle phase
    a_r2_settle_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(measure_o) |-> $past(phase_q) == PH_SETTLE);

endmodule

// File: rtl/osc_cycle_counter.sv
// Module: counts fast-clock cycles while the window is open and holds at
// its maximum value instead of wrapping.
// Assumes clear_i and enable_i are never high together.
module osc_cycle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             enable_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Saturating up-counter with a synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_o <= '0;
        end else if (enable_i && count_o != CNT_MAX) begin
            count_o <= count_o + 1'b1;
        end
    end

    // R8: once at the maximum the count stays there until cleared
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX && !clear_i) |=> count_o == CNT_MAX);

endmodule

// File: rtl/osc_classifier.sv
// Module: scales the cycle count, classifies it through the threshold ladder
// and registers the select code, divider ratio and table index.
// Assumes load_i is a one-cycle pulse issued once per measurement.
module osc_classifier
    import osc_cls_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             dbl_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [2:0]       sel_code_o,
    output logic [1:0]       div_ratio_o,
    output logic [1:0]       tbl_idx_o,
    output logic             done_o
);
    localparam int SW = CNT_W + 1;

    logic [SW-1:0] scaled;
    logic [2:0]    code_c;
    logic [1:0]    ratio_c, idx_c;

    // Double the count when the measured clock is pre-divided
    assign scaled = dbl_i ? {count_i, 1'b0} : {1'b0, count_i};

    // Walk the ladder lowest first so the highest matching step wins
    always_comb begin
        code_c = 3'd0;
        for (int k = NUM_CLASSES - 1; k >= 0; k--) begin
            if (scaled > SW'(LADDER_TH[k])) code_c = LADDER_CD[k];
        end
    end

    // Derive divider ratio and table index from the code
    always_comb begin
        if (code_c > 3'd2) begin
            ratio_c = 2'd2;
            idx_c   = code_c[2:1];
        end else begin
            ratio_c = 2'd1;
            idx_c   = code_c[1:0];
        end
    end

    // Hold results between reports and raise done for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_code_o  <= 3'd0;
            div_ratio_o <= 2'd1;
            tbl_idx_o   <= 2'd0;
            done_o      <= 1'b0;
        end else begin
            done_o <= load_i;
            if (load_i) begin
                sel_code_o  <= code_c;
                div_ratio_o <= ratio_c;
                tbl_idx_o   <= idx_c;
            end
        end
    end

    // R6: no code beyond the five defined values ever appears
    a_r6_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        sel_code_o <= 3'd4);

    // R7: a ratio of two always pairs with an index of half the code
    a_r7_div_index: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ratio_o == 2'd2) |-> (sel_code_o > 3'd2 && tbl_idx_o == sel_code_o[2:1]));

    // R10: results only change in the cycle done is high
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(sel_code_o) || $past(!rst_n));

endmodule

// File: rtl/osc_freq_classifier.sv
// Module: top of the reference oscillator classifier. Measures the fast clock
// against the reference clock once per accepted start and reports the class.
// Assumes ref_clk_i levels last at least two fast cycles.
module osc_freq_classifier #(
    parameter int CNT_W        = 16,
    parameter int SETTLE_TICKS = 20,
    parameter int WINDOW_TICKS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       ref_clk_i,
    input  logic       pre_div2_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [2:0] sel_code_o,
    output logic [1:0] div_ratio_o,
    output logic [1:0] tbl_idx_o
);
    logic             ref_tick, accept, measure, report;
    logic [CNT_W-1:0] cycles;
    logic             dbl_q;

    osc_ref_sync u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_async_i (ref_clk_i),
        .ref_tick_o  (ref_tick)
    );

    osc_window_ctrl #(
        .SETTLE_TICKS (SETTLE_TICKS),
        .WINDOW_TICKS (WINDOW_TICKS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ref_tick_i (ref_tick),
        .accept_o   (accept),
        .measure_o  (measure),
        .report_o   (report),
        .busy_o     (busy_o)
    );

    // Capture the pre-divide flag when a measurement is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)      dbl_q <= 1'b0;
        else if (accept) dbl_q <= pre_div2_i;
    end

    osc_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .enable_i (measure),
        .count_o  (cycles)
    );

    osc_classifier #(.CNT_W(CNT_W)) u_cls (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (report),
        .dbl_i       (dbl_q),
        .count_i     (cycles),
        .sel_code_o  (sel_code_o),
        .div_ratio_o (div_ratio_o),
        .tbl_idx_o   (tbl_idx_o),
        .done_o      (done_o)
    );

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: busy and done are never high together
    a_r9_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

endmodule

// File: tb/osc_freq_classifier_tb_top.sv
module osc_freq_classifier_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       ref_clk_i = 1'b0;
    logic       pre_div2_i = 1'b0;
    logic       busy_o, done_o;
    logic [2:0] sel_code_o;
    logic [1:0] div_ratio_o, tbl_idx_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_freq_classifier dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .ref_clk_i   (ref_clk_i),
        .pre_div2_i  (pre_div2_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .sel_code_o  (sel_code_o),
        .div_ratio_o (div_ratio_o),
        .tbl_idx_o   (tbl_idx_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected select code from the requirement ladder (R5, R6)
    function automatic int exp_code(input int raw, input bit dbl);
        int v;
        v = dbl ? raw * 2 : raw;
        if (v > 65535 * (dbl ? 2 : 1)) v = 65535 * (dbl ? 2 : 1);
        if (v > 19000) return 4;
        if (v > 15200) return 3;
        if (v > 13000) return 0;
        if (v > 9000)  return 2;
        if (v > 7600)  return 1;
        return 0;
    endfunction

    // One full measurement: start, 20 short settle edges, then a window of raw cycles
    task automatic measure(input string req, input int raw, input bit dbl, input bit mid_start);
        int base, code, len, hi;
        bit seen;
        pre_div2_i = dbl;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check("R9", "busy after start", busy_o, 1);
        @(negedge clk); @(negedge clk);
        base = raw / 20;
        for (int i = 1; i <= 40; i++) begin
            if (i < 20)       len = 6;
            else if (i < 39)  len = base;
            else if (i == 39) len = raw - 19 * base;
            else              len = 4;
            hi = len / 2;
            ref_clk_i = 1'b1;
            for (int c = 0; c < len; c++) begin
                start_i = (mid_start && i == 30 && c == 1);
                @(negedge clk);
                if (c == hi - 1) ref_clk_i = 1'b0;
                if (mid_start && i == 30 && c == 2)
                    check("R9", "busy during ignored start", busy_o, 1);
            end
        end
        start_i = 1'b0;
        seen = 0;
        for (int w = 0; w < 20 && !seen; w++) begin
            if (done_o) seen = 1;
            else @(negedge clk);
        end
        check(req, "done seen", seen, 1);
        code = exp_code(raw, dbl);
        check(req, "select code", sel_code_o, code);
        check("R7", "divider ratio", div_ratio_o, code > 2 ? 2 : 1);
        check("R7", "table index", tbl_idx_o, code > 2 ? code / 2 : code);
        check("R9", "busy low with done", busy_o, 0);
        @(negedge clk);
        check("R9", "done one cycle", done_o, 0);
        check("R10", "code held", sel_code_o, code);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy", busy_o, 0);
        check("R1", "done", done_o, 0);
        check("R1", "select code", sel_code_o, 0);
        check("R1", "divider ratio", div_ratio_o, 1);
        check("R1", "table index", tbl_idx_o, 0);
    endtask

    task automatic t_low_boundary();
        measure("R3", 7600, 1'b0, 1'b0);   // 12 MHz, code 0
        measure("R2", 7601, 1'b0, 1'b0);   // 13 MHz, code 1
    endtask

    task automatic t_ladder();
        measure("R5", 12000, 1'b0, 1'b0);  // 19.2 MHz, code 2
        measure("R6", 14000, 1'b0, 1'b0);  // 24 MHz, code 0
    endtask

    task automatic t_predivide();
        measure("R4", 9500, 1'b1, 1'b0);   // 19000 -> 26 MHz, code 3
        measure("R4", 9501, 1'b1, 1'b0);   // 19002 -> 38.4 MHz, code 4
        measure("R4", 3800, 1'b1, 1'b0);   // 7600 -> 12 MHz, code 0
    endtask

    task automatic t_busy_ignore();
        measure("R9", 9200, 1'b0, 1'b1);   // restart would shift the count
    endtask

    task automatic t_saturate();
        measure("R8", 65600, 1'b0, 1'b0);  // wrap would give 64 -> code 0
    endtask

    initial begin
        t_reset();
        t_low_boundary();
        t_ladder();
        t_predivide();
        t_busy_ignore();
        t_saturate();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < WATCHDOG; k++) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule